// File: doc/BRIEF.md
# DMA Address Translation Unit

This unit sits between a DMA-capable device and system memory. It turns a device virtual address into a physical address. Translation is controlled by two register values that the surrounding logic supplies: a control word and a table base. When translation is enabled, the unit reads one 64-bit translation entry from a single linear table in memory. The table index is a slice of the virtual address. The width of that slice is set by a 3-bit size code and by a table-wide choice of 8 KB or 64 KB indexing. The entry then gives the frame address, the page size and the write permission.

A request is accepted with a valid/ready handshake, and the unit handles only one translation at a time. The control word and the base are sampled when the request is accepted. The unit issues one fetch on a simple read port and waits for the memory's data-valid strobe, however long it takes. The result is held on the response port, together with its valid flag, until the consumer takes it.

The response carries four values: the page-aligned input address, the physical address, the page offset mask and the permission.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0.
- R2: A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 until the response is taken. rsp_valid_o stays 1 and every response field stays stable until a clock edge where rsp_ready_i is 1; the next cycle rsp_valid_o is 0.
- R3: When control bit 0 is 0, no fetch is made. The response is: rsp_pa_o = VA, rsp_iova_o = VA & ~0x1FFF, rsp_mask_o = 0x1FFF and rsp_perm_o = 2 (read-write).
- R4: When control bit 0 is 1 and control bit 2 is 0, the size code n = control bits 18:16 (0 to 7) selects VA bits 13 through 22+n as the index. The fetch address is base + index*8.
- R5: When control bits 0 and 2 are both 1 and n is 0 to 5, VA bits 16 through 25+n form the index. The fetch address is base + index*8.
- R6: When control bits 0 and 2 are both 1 and n is 6 or 7, no fetch is made. The response is: perm 0 (none), pa 0, iova 0, and a mask of all ones.
- R7: The entry is big-endian. The memory byte at the fetch address arrives on mem_rdata_i[7:0] and becomes entry bits 63:56. Each following byte lane holds the next address and the next lower entry byte.
- R8: If entry bit 63 is 0, the response is perm 0, pa 0, iova 0 and a mask of all ones.
- R9: For a valid entry, bit 1 set gives perm 2 (read-write). Bit 1 clear gives perm 1 (read-only).
- R10: For a valid entry with bit 61 set: pa = entry & 0x1FFFFFF8000, mask = 0xFFFF, iova = VA & ~0xFFFF. With bit 61 clear: pa = entry & 0x1FFFFFFE000, mask = 0x1FFF, iova = VA & ~0x1FFF.
- R11: Each request that needs a fetch raises mem_req_o for exactly one cycle. The response follows a mem_rvalid_i that may arrive any number of cycles after the request, starting one cycle after it.
- R12: Changes to ctrl_i or base_i after a request has been taken do not affect that request's fetch address or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| req_va_i | input | ADDR_W | Device virtual address |
| ctrl_i | input | CTRL_W | Control word: bit 0 enable, bit 2 64 KB indexing, bits 18:16 size code |
| base_i | input | ADDR_W | Table base address |
| mem_req_o | output | 1 | One-cycle fetch request |
| mem_addr_o | output | ADDR_W | Fetch byte address |
| mem_rvalid_i | input | 1 | Fetch data valid |
| mem_rdata_i | input | 64 | Fetched bytes, lowest address in bits 7:0 |
| rsp_valid_o | output | 1 | Response held valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_iova_o | output | ADDR_W | Page-aligned input address |
| rsp_pa_o | output | ADDR_W | Physical address |
| rsp_mask_o | output | ADDR_W | Page offset mask |
| rsp_perm_o | output | 2 | 0 none, 1 read-only, 2 read-write |

## Verification
The hardest case to reach is the one in R12. A request must be taken, and then ctrl_i and base_i must move while the fetch is still pending in a memory that is slow to answer. Only then does a design that samples these inputs late show a wrong fetch address or wrong result fields. To get there, the bench scrambles both inputs in the cycle right after every acceptance. Its memory model answers after a random latency, and the consumer holds off acceptance for a random time. The highest slice bits at size codes 7 (8 KB indexing) and 5 (64 KB indexing) are hit with directed addresses, as are the rejected 64 KB codes 6 and 7.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
   typedef enum logic [1:0] {
      PERM_NONE = 2'd0,
      PERM_RO   = 2'd1,
      PERM_RW   = 2'd2
   } perm_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RESP  = 2'd3
   } xlate_state_e;

   localparam int ENTRY_W        = 64;
   localparam int ENTRY_VALID    = 63;
   localparam int ENTRY_BIG_PAGE = 61;
   localparam int ENTRY_WRITE    = 1;

   localparam int CTRL_ENABLE    = 0;
   localparam int CTRL_WIDE_IDX  = 2;
   localparam int CTRL_CODE_LSB  = 16;
   localparam int CODE_W         = 3;
   localparam int WIDE_CODE_MAX  = 5;

   localparam int SMALL_LSB      = 13;
   localparam int LARGE_LSB      = 16;
   localparam int SLICE_MIN_BITS = 10;
   localparam int ENTRY_SHIFT    = 3;

   localparam logic [63:0] LARGE_FRAME = 64'h0000_01FF_FFFF_8000;
   localparam logic [63:0] SMALL_FRAME = 64'h0000_01FF_FFFF_E000;
   localparam logic [63:0] LARGE_OFF   = 64'h0000_0000_0000_FFFF;
   localparam logic [63:0] SMALL_OFF   = 64'h0000_0000_0000_1FFF;
endpackage

// File: rtl/dma_xlate_index.sv
module dma_xlate_index
   import dma_xlate_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] va_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              wide_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic              legal_o
);
   int                lo;
   int                nbits;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] picked;

   always_comb begin
      lo    = wide_i ? LARGE_LSB : SMALL_LSB;
      nbits = SLICE_MIN_BITS + int'(code_i);
   end

   // per-bit slice window, width grows with the size code
   for (genvar b = 0; b < ADDR_W; b++) begin : g_span
      assign span[b] = (b >= lo) && (b < lo + nbits);
   end

   assign picked       = va_i & span;
   assign fetch_addr_o = base_i + (picked >> (lo - ENTRY_SHIFT));
   assign legal_o      = !(wide_i && (int'(code_i) > WIDE_CODE_MAX));
endmodule

// File: rtl/dma_xlate_byteorder.sv
module dma_xlate_byteorder #(
   parameter bit BIG_ENDIAN = 1'b1,
   parameter int WORD_BYTES = 8
) (
   input  logic [8*WORD_BYTES-1:0] raw_i,
   output logic [8*WORD_BYTES-1:0] word_o
);
   if (BIG_ENDIAN) begin : g_swap
      for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
         assign word_o[8*k +: 8] = raw_i[8*(WORD_BYTES-1-k) +: 8];
      end
   end else begin : g_keep
      assign word_o = raw_i;
   end
endmodule

// File: rtl/dma_xlate_decode.sv
module dma_xlate_decode
   import dma_xlate_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ENTRY_W-1:0] entry_i,
   input  logic [ADDR_W-1:0]  va_i,
   output logic [ADDR_W-1:0]  iova_o,
   output logic [ADDR_W-1:0]  pa_o,
   output logic [ADDR_W-1:0]  mask_o,
   output perm_e              perm_o
);
   localparam logic [ADDR_W-1:0] L_OFF = ADDR_W'(LARGE_OFF);
   localparam logic [ADDR_W-1:0] S_OFF = ADDR_W'(SMALL_OFF);

   always_comb begin
      if (!entry_i[ENTRY_VALID]) begin
         iova_o = '0;
         pa_o   = '0;
         mask_o = '1;
         perm_o = PERM_NONE;
      end else begin
         perm_o = entry_i[ENTRY_WRITE] ? PERM_RW : PERM_RO;
         if (entry_i[ENTRY_BIG_PAGE]) begin
            pa_o   = ADDR_W'(entry_i & LARGE_FRAME);
            mask_o = L_OFF;
            iova_o = va_i & ~L_OFF;
         end else begin
            pa_o   = ADDR_W'(entry_i & SMALL_FRAME);
            mask_o = S_OFF;
            iova_o = va_i & ~S_OFF;
         end
      end
   end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
   import dma_xlate_pkg::*;
#(
   parameter int ADDR_W           = 64,
   parameter int CTRL_W           = 64,
   parameter bit BIG_ENDIAN_FETCH = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [ADDR_W-1:0] req_va_i,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [63:0]       mem_rdata_i,
   output logic              rsp_valid_o,
   input  logic              rsp_ready_i,
   output logic [ADDR_W-1:0] rsp_iova_o,
   output logic [ADDR_W-1:0] rsp_pa_o,
   output logic [ADDR_W-1:0] rsp_mask_o,
   output logic [1:0]        rsp_perm_o
);
   localparam int CODE_MSB = CTRL_CODE_LSB + CODE_W - 1;
   localparam logic [ADDR_W-1:0] PASS_OFF = ADDR_W'(SMALL_OFF);

   if (ADDR_W < 41 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ADDR_W must lie between 41 and 64");
   end
   if (CTRL_W <= CODE_MSB) begin : g_bad_ctrl_w
      $error("CTRL_W too narrow for the size code field");
   end

   xlate_state_e      state_q;
   logic [ADDR_W-1:0] va_q, base_q;
   logic              en_q, wide_q;
   logic [CODE_W-1:0] code_q;
   logic [ADDR_W-1:0] fetch_addr;
   logic              legal;
   logic [63:0]       entry;
   logic [ADDR_W-1:0] dec_iova, dec_pa, dec_mask;
   perm_e             dec_perm;

   dma_xlate_index #(.ADDR_W(ADDR_W)) index_i (
      .va_i        (va_q),
      .base_i      (base_q),
      .wide_i      (wide_q),
      .code_i      (code_q),
      .fetch_addr_o(fetch_addr),
      .legal_o     (legal)
   );

   dma_xlate_byteorder #(.BIG_ENDIAN(BIG_ENDIAN_FETCH), .WORD_BYTES(8)) order_i (
      .raw_i (mem_rdata_i),
      .word_o(entry)
   );

   dma_xlate_decode #(.ADDR_W(ADDR_W)) decode_i (
      .entry_i(entry),
      .va_i   (va_q),
      .iova_o (dec_iova),
      .pa_o   (dec_pa),
      .mask_o (dec_mask),
      .perm_o (dec_perm)
   );

   assign req_ready_o = (state_q == ST_IDLE);
   assign rsp_valid_o = (state_q == ST_RESP);
   assign mem_req_o   = (state_q == ST_ISSUE) && en_q && legal;
   assign mem_addr_o  = fetch_addr;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         va_q       <= '0;
         base_q     <= '0;
         en_q       <= 1'b0;
         wide_q     <= 1'b0;
         code_q     <= '0;
         rsp_iova_o <= '0;
         rsp_pa_o   <= '0;
         rsp_mask_o <= '0;
         rsp_perm_o <= PERM_NONE;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  va_q    <= req_va_i;
                  base_q  <= base_i;
                  en_q    <= ctrl_i[CTRL_ENABLE];
                  wide_q  <= ctrl_i[CTRL_WIDE_IDX];
                  code_q  <= ctrl_i[CODE_MSB:CTRL_CODE_LSB];
                  state_q <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (!en_q) begin
                  rsp_iova_o <= va_q & ~PASS_OFF;
                  rsp_pa_o   <= va_q;
                  rsp_mask_o <= PASS_OFF;
                  rsp_perm_o <= PERM_RW;
                  state_q    <= ST_RESP;
               end else if (!legal) begin
                  rsp_iova_o <= '0;
                  rsp_pa_o   <= '0;
                  rsp_mask_o <= '1;
                  rsp_perm_o <= PERM_NONE;
                  state_q    <= ST_RESP;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rvalid_i) begin
                  rsp_iova_o <= dec_iova;
                  rsp_pa_o   <= dec_pa;
                  rsp_mask_o <= dec_mask;
                  rsp_perm_o <= dec_perm;
                  state_q    <= ST_RESP;
               end
            end
            default: begin
               if (rsp_ready_i) state_q <= ST_IDLE;
            end
         endcase
      end
   end

   // R2: idle only when nothing is pending on either side
   assert_ready_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o |-> (!rsp_valid_o && !mem_req_o));

   // R2: a response waiting on the consumer holds still
   assert_rsp_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_pa_o)
         && $stable(rsp_iova_o) && $stable(rsp_mask_o) && $stable(rsp_perm_o)));

   // R11: a fetch request lasts one cycle
   assert_single_fetch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |=> !mem_req_o);

   // R3: disabled translation never touches memory
   assert_pass_nofetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && !ctrl_i[CTRL_ENABLE]) |=> !mem_req_o);

   // R6: rejected wide codes never touch memory
   assert_bad_code_nofetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && ctrl_i[CTRL_ENABLE] && ctrl_i[CTRL_WIDE_IDX]
         && (int'(ctrl_i[CODE_MSB:CTRL_CODE_LSB]) > WIDE_CODE_MAX)) |=> !mem_req_o);

   // R8: a no-permission result carries zero addresses
   assert_none_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_perm_o == PERM_NONE) |-> (rsp_pa_o == '0 && rsp_iova_o == '0));
endmodule

// File: tb/dma_xlate_unit_tb_top.sv
module dma_xlate_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_va = '0;
   logic [63:0] ctrl = '0;
   logic [63:0] base = '0;
   logic        mem_req;
   logic [63:0] mem_addr;
   logic        m_rvalid = 1'b0;
   logic [63:0] m_rdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [63:0] rsp_iova, rsp_pa, rsp_mask;
   logic [1:0]  rsp_perm;

   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;
   int          fetch_cnt = 0;
   logic [63:0] last_fetch = '0;
   logic        m_pend = 1'b0;
   logic [63:0] m_addr = '0;
   int          m_cnt = 0;
   logic [63:0] mem_over [logic [63:0]];

   always #10 clk = ~clk;

   dma_xlate_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
      .ctrl_i(ctrl), .base_i(base),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr),
      .mem_rvalid_i(m_rvalid), .mem_rdata_i(m_rdata),
      .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
      .rsp_iova_o(rsp_iova), .rsp_pa_o(rsp_pa), .rsp_mask_o(rsp_mask),
      .rsp_perm_o(rsp_perm)
   );

   function automatic logic [63:0] entry_at(input logic [63:0] a);
      if (mem_over.exists(a)) return mem_over[a];
      return (a * 64'h9E37_79B9_7F4A_7C15) ^ (a >> 7) ^ 64'h5A5A_0F0F_3C3C_9696;
   endfunction

   // big-endian lanes: lowest address byte in bits 7:0 carries entry bits 63:56 (R7)
   function automatic logic [63:0] to_lanes(input logic [63:0] e);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = e[8*(7-k) +: 8];
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend   <= 1'b0;
         m_rvalid <= 1'b0;
      end else begin
         m_rvalid <= 1'b0;
         if (mem_req) begin
            m_pend     <= 1'b1;
            m_addr     <= mem_addr;
            m_cnt      <= $urandom_range(0, 4);
            fetch_cnt  <= fetch_cnt + 1;
            last_fetch <= mem_addr;
         end else if (m_pend) begin
            if (m_cnt == 0) begin
               m_rvalid <= 1'b1;
               m_rdata  <= to_lanes(entry_at(m_addr));
               m_pend   <= 1'b0;
            end else begin
               m_cnt <= m_cnt - 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic expect_xlate(input logic [63:0] va, input logic [63:0] c, input logic [63:0] b,
                               output bit fetch, output logic [63:0] faddr,
                               output logic [63:0] iova, output logic [63:0] pa,
                               output logic [63:0] mask, output logic [1:0] perm,
                               output string tag);
      int          code;
      int          lsb;
      logic [63:0] idx;
      logic [63:0] e;
      code  = int'(c[18:16]);
      fetch = 0;
      faddr = '0;
      if (!c[0]) begin
         pa = va; iova = va & ~64'h1FFF; mask = 64'h1FFF; perm = 2'd2; tag = "R3";
      end else if (c[2] && code > 5) begin
         pa = '0; iova = '0; mask = '1; perm = 2'd0; tag = "R6";
      end else begin
         lsb   = c[2] ? 16 : 13;
         idx   = (va >> lsb) & ((64'd1 << (10 + code)) - 64'd1);
         faddr = b + (idx << 3);
         fetch = 1;
         e     = entry_at(faddr);
         if (!e[63]) begin
            pa = '0; iova = '0; mask = '1; perm = 2'd0; tag = "R8";
         end else begin
            perm = e[1] ? 2'd2 : 2'd1;
            tag  = "R9/R10";
            if (e[61]) begin
               pa = e & 64'h1FF_FFFF_8000; mask = 64'hFFFF; iova = va & ~64'hFFFF;
            end else begin
               pa = e & 64'h1FF_FFFF_E000; mask = 64'h1FFF; iova = va & ~64'h1FFF;
            end
         end
      end
   endtask

   task automatic run(input logic [63:0] va, input logic [63:0] c, input logic [63:0] b,
                      input int hold, input string extra);
      bit          fetch;
      logic [63:0] faddr, iova, pa, mask;
      logic [1:0]  perm;
      string       tag;
      int          f0;
      int          n;
      logic [63:0] snap;
      expect_xlate(va, c, b, fetch, faddr, iova, pa, mask, perm, tag);
      @(negedge clk);
      req_va = va; ctrl = c; base = b; req_valid = 1'b1;
      f0 = fetch_cnt;
      chk(req_ready == 1'b1, "R2", "ready while idle", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      // R12: scramble the configuration while the request is in flight
      ctrl = {$urandom, $urandom};
      base = {$urandom, $urandom};
      req_va = {$urandom, $urandom};
      n = 0;
      while (!rsp_valid && n < 100) begin
         chk(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'd0);
         @(negedge clk);
         n++;
      end
      chk(rsp_valid == 1'b1, "R11", "response arrives", 64'(rsp_valid), 64'd1);
      snap = rsp_pa;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_pa == snap && !req_ready, "R2", "held response",
             rsp_pa, snap);
      end
      chk(rsp_perm == perm, {tag, extra}, "perm", 64'(rsp_perm), 64'(perm));
      chk(rsp_pa == pa, {tag, extra}, "pa", rsp_pa, pa);
      chk(rsp_iova == iova, {tag, extra}, "iova", rsp_iova, iova);
      chk(rsp_mask == mask, {tag, extra}, "mask", rsp_mask, mask);
      chk(fetch_cnt - f0 == (fetch ? 1 : 0), "R11", "fetch count",
          64'(fetch_cnt - f0), 64'(fetch ? 1 : 0));
      if (fetch)
         chk(last_fetch == faddr, c[2] ? "R5" : "R4", "fetch address", last_fetch, faddr);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(rsp_valid == 1'b0, "R2", "response released", 64'(rsp_valid), 64'd0);
   endtask

   function automatic logic [63:0] mk_ctrl(input bit en, input bit wide, input int code);
      logic [63:0] c;
      c        = '0;
      c[0]     = en;
      c[2]     = wide;
      c[18:16] = 3'(code);
      return c;
   endfunction

   initial begin
      void'($urandom(32'd12345));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'd0);

      // R3 passthrough
      run(64'h1234_5678_9ABC_DEF1, mk_ctrl(0, 0, 0), 64'h4000, 1, " R3");
      run(64'h0000_0000_0000_1FFF, mk_ctrl(0, 1, 7), 64'h4000, 0, " R3");

      // R4 code 0, writable small page
      mem_over[64'h10_0000 + (64'h3FF << 3)] = 64'h8000_00AB_CDEF_3002;
      run(64'h0000_0000_007F_E123, mk_ctrl(1, 0, 0), 64'h10_0000, 2, " R4");
      // R4 code 7, top slice bit 29
      run(64'h0000_0000_2000_2000, mk_ctrl(1, 0, 7), 64'h20_0000, 0, " R4");
      // R5 code 5, read-only large page, top slice bit 30
      mem_over[64'h30_0000 + (64'h4001 << 3)] = 64'hA000_0123_4567_FFFC;
      run(64'h0000_0000_4001_ABCD, mk_ctrl(1, 1, 5), 64'h30_0000, 1, " R5");
      // R6 rejected wide codes
      run(64'h0000_0000_1234_5678, mk_ctrl(1, 1, 6), 64'h30_0000, 0, " R6");
      run(64'h0000_0000_1234_5678, mk_ctrl(1, 1, 7), 64'h30_0000, 3, " R6");
      // R8 invalid entry
      mem_over[64'h40_0000] = 64'h7FFF_FFFF_FFFF_FFFF;
      run(64'h0000_0000_0000_0000, mk_ctrl(1, 0, 3), 64'h40_0000, 0, " R8");
      // R7 byte order: distinct bytes, only the top one carries the valid bit
      mem_over[64'h50_0008] = 64'h8001_0203_0405_0607;
      run(64'h0000_0000_0000_2000, mk_ctrl(1, 0, 0), 64'h50_0000, 0, " R7");
      // R12 scrambled configuration after acceptance on a slow fetch
      run(64'h0000_0000_0ABC_DE00, mk_ctrl(1, 1, 2), 64'h60_0000, 2, " R12");

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         logic [63:0] va;
         logic [63:0] c;
         logic [63:0] b;
         va = {$urandom, $urandom};
         b  = {32'd0, $urandom} & ~64'h7;
         c  = mk_ctrl(($urandom % 4) != 0, $urandom % 2 == 1, int'($urandom % 8));
         c  = c | ({$urandom, $urandom} & 64'hFFFF_FFFF_FFF8_FFFA);
         run(va, c, b, int'($urandom % 4), " R12");
      end

      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual=%h expected=%h", 64'd1, 64'd0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule